// File: doc/BRIEF.md
# Tone Transceiver Host Register Interface

This block is the processor-facing register front end of a telephone tone transceiver. A one-bit register-select input and the read/write controls are decoded into four accesses: writing the transmit digit, reading the received digit, writing a control register and reading status. A strap input chooses between two bus styles. One style uses a read/write level plus an enable. The other uses separate active-low read and write strobes. Each strobe assertion counts as exactly one access, no matter how long the strobe is held.

Two 4-bit control registers share the single control address. When a write to the first register (A) has bit 3 set, the next control write goes to the second register (B). After that write, the pointer falls back to A. Register A gates the tone output, selects between digit detection and call-progress mode, and enables the interrupt. Register B carries the transmit options. The tone generator and detector are outside the block. They appear as a receive-valid pulse with a code, a transmit-complete pulse and a squared call-progress tone input.

A single active-low output serves two purposes. In digit mode it is an interrupt line that a status read releases. In call-progress mode it is a synchronized copy of the received tone.

Top module: `tone_host_regif`

## Requirements
- R1: An access is taken once, on the first cycle its strobe is active. With `bus_style`=1 the strobe is `bus_en`, and `rw_n`=1 means read. With `bus_style`=0 the strobe is `rd_n` or `wr_n` low. Holding a strobe for several cycles still makes one access. `reg_sel`=0 selects the data registers (transmit on write, receive on read). `reg_sel`=1 selects control on write and status on read.
- R2: A read loads `rdata` on the clock edge that takes the access, and `rdata` holds that value until the next read. The status value has bit 0 interrupt pending, bit 1 receive ready, bit 2 transmit empty and bit 3 zero.
- R3: A control write goes to register A unless the previous control write was to A with bit 3 set. In that case it goes to B, leaves A's other bits unchanged, and clears the pointer back to A.
- R4: Register A bit 0 drives `tone_on`, bit 1 drives `cp_mode` and bit 2 drives `irq_en`. Register B bit 0 drives `burst_en`, bit 1 drives `test_en`, bit 2 drives `single_tone` and bit 3 drives `col_row`.
- R5: While `tone_on` is 0, `tx_pwrdn` is 1, and a transmit data write is ignored: there is no `tx_load`, `tx_data` is unchanged and transmit empty stays set.
- R6: With `tone_on` at 1, a transmit data write stores `tx_data`, pulses `tx_load` for one cycle after the access edge, and clears transmit empty until `tx_done`.
- R7: In digit mode, `rx_valid` latches `rx_code` and sets receive ready, and a receive data read clears receive ready. In call-progress mode, `rx_valid` is ignored.
- R8: In digit mode with `irq_en` at 1, pending is set by `rx_valid`, or by `tx_done` while `burst_en` is 1. `irq_cp_n` goes low one cycle after pending is set. A status read clears pending, and `irq_cp_n` returns high the cycle after.
- R9: In call-progress mode with `irq_en` at 1, `irq_cp_n` is the inverse of `cp_tone`, delayed by SYNC_STAGES+1 cycles.
- R10: With `irq_en` at 0, `irq_cp_n` stays high and events do not set pending.
- R11: Reset clears both control registers, points control writes at A, clears pending and receive ready, sets transmit empty and drives `irq_cp_n` high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| bus_style | input | 1 | Bus style strap: 1 = read/write level plus enable, 0 = separate strobes |
| reg_sel | input | 1 | Register select: 0 = data registers, 1 = control/status |
| rw_n | input | 1 | Read (1) / write (0) level, used when bus_style is 1 |
| bus_en | input | 1 | Access enable, active high, used when bus_style is 1 |
| rd_n | input | 1 | Read strobe, active low, used when bus_style is 0 |
| wr_n | input | 1 | Write strobe, active low, used when bus_style is 0 |
| wdata | input | 4 | Write data |
| rdata | output | 4 | Read data |
| rx_valid | input | 1 | Detector pulse: a digit has been held for the guard time |
| rx_code | input | 4 | Detected digit code |
| tx_done | input | 1 | Transmitter pulse: digit sent, ready for more |
| cp_tone | input | 1 | Squared call-progress tone from the detector |
| tx_data | output | 4 | Digit for the transmitter |
| tx_load | output | 1 | One-cycle pulse: new transmit digit |
| tx_pwrdn | output | 1 | Transmitter power-down |
| tone_on | output | 1 | Tone output enabled |
| cp_mode | output | 1 | Call-progress mode selected |
| irq_en | output | 1 | Interrupt function enabled |
| burst_en | output | 1 | Burst transmit option |
| test_en | output | 1 | Test option |
| single_tone | output | 1 | Single-tone transmit option |
| col_row | output | 1 | Column/row tone choice for single-tone transmit |
| irq_cp_n | output | 1 | Active-low interrupt, or the call-progress tone |

## Verification
The embedded properties check the following on every cycle: an access never repeats on the cycle after it was taken; a write routed to B always returns the pointer to A and leaves A's low bits alone; a status read without a new event clears pending; call-progress mode never raises receive ready; tone-off never produces a load; and a disabled interrupt keeps the output high. Only the bench's scenarios can show the rest. This covers the data values returned on reads in both bus styles, the exact status encodings after sequences of receive and transmit events, a held strobe that must not repeat a pointer-changing write, and the delayed tracking of the call-progress tone.

// File: rtl/tone_regif_pkg.sv
package tone_regif_pkg;

    localparam int DW = 4;

    typedef enum logic {
        BUS_STROBES = 1'b0,
        BUS_RW_EN   = 1'b1
    } bus_style_e;

    typedef struct packed {
        logic tx_wr;
        logic rx_rd;
        logic ctl_wr;
        logic st_rd;
    } access_t;

    typedef struct packed {
        logic to_b;
        logic irq_en;
        logic cp_mode;
        logic tone_on;
    } ctl_a_t;

    typedef struct packed {
        logic col_row;
        logic single_tone;
        logic test_en;
        logic burst_en;
    } ctl_b_t;

    typedef struct packed {
        logic spare;
        logic tx_empty;
        logic rx_ready;
        logic pend;
    } status_t;

    function automatic logic [DW-1:0] pack_status(status_t s);
        status_t r;
        r       = s;
        r.spare = 1'b0;
        return r;
    endfunction

endpackage

// File: rtl/tone_bus_decode.sv
module tone_bus_decode
    import tone_regif_pkg::*;
(
    input  logic    clk,
    input  logic    rst,
    input  logic    bus_style,
    input  logic    reg_sel,
    input  logic    rw_n,
    input  logic    bus_en,
    input  logic    rd_n,
    input  logic    wr_n,
    output access_t acc
);
    logic active, is_read, active_q, first;

    always_comb begin
        if (bus_style_e'(bus_style) == BUS_RW_EN) begin
            active  = bus_en;
            is_read = rw_n;
        end else begin
            active  = !rd_n || !wr_n;
            is_read = !rd_n;
        end
    end

    always_ff @(posedge clk) begin
        if (rst) active_q <= 1'b0;
        else     active_q <= active;
    end

    assign first      = active && !active_q;
    assign acc.tx_wr  = first && !is_read && !reg_sel;
    assign acc.rx_rd  = first &&  is_read && !reg_sel;
    assign acc.ctl_wr = first && !is_read &&  reg_sel;
    assign acc.st_rd  = first &&  is_read &&  reg_sel;

    // R1
    single_access_chk: assert property (@(posedge clk) disable iff (rst)
        (acc != '0) |=> (acc == '0));
endmodule

// File: rtl/tone_ctrl_regs.sv
module tone_ctrl_regs
    import tone_regif_pkg::*;
(
    input  logic          clk,
    input  logic          rst,
    input  logic          ctl_wr,
    input  logic [DW-1:0] wdata,
    output ctl_a_t        cra,
    output ctl_b_t        crb
);
    always_ff @(posedge clk) begin
        if (rst) begin
            cra <= '0;
            crb <= '0;
        end else if (ctl_wr) begin
            if (cra.to_b) begin
                crb      <= ctl_b_t'(wdata);
                cra.to_b <= 1'b0;
            end else begin
                cra <= ctl_a_t'(wdata);
            end
        end
    end

    // R3
    b_write_returns_chk: assert property (@(posedge clk) disable iff (rst)
        (ctl_wr && cra.to_b) |=> (!cra.to_b && (cra[2:0] == $past(cra[2:0]))));
endmodule

// File: rtl/tone_event_status.sv
module tone_event_status
    import tone_regif_pkg::*;
(
    input  logic          clk,
    input  logic          rst,
    input  access_t       acc,
    input  ctl_a_t        cra,
    input  ctl_b_t        crb,
    input  logic [DW-1:0] wdata,
    input  logic          rx_valid,
    input  logic [DW-1:0] rx_code,
    input  logic          tx_done,
    output status_t       st,
    output logic [DW-1:0] rx_data,
    output logic [DW-1:0] tx_data,
    output logic          tx_load
);
    logic set_rx, set_pend, take_tx;

    assign set_rx   = rx_valid && !cra.cp_mode;
    assign set_pend = cra.irq_en && !cra.cp_mode &&
                      (rx_valid || (tx_done && crb.burst_en));
    assign take_tx  = acc.tx_wr && cra.tone_on;

    always_ff @(posedge clk) begin
        if (rst) begin
            st      <= '{spare: 1'b0, tx_empty: 1'b1, rx_ready: 1'b0, pend: 1'b0};
            rx_data <= '0;
            tx_data <= '0;
            tx_load <= 1'b0;
        end else begin
            tx_load <= take_tx;
            if (take_tx) tx_data <= wdata;
            if (set_rx)  rx_data <= rx_code;

            if (set_pend)       st.pend <= 1'b1;
            else if (acc.st_rd) st.pend <= 1'b0;

            if (set_rx)         st.rx_ready <= 1'b1;
            else if (acc.rx_rd) st.rx_ready <= 1'b0;

            if (tx_done)        st.tx_empty <= 1'b1;
            else if (take_tx)   st.tx_empty <= 1'b0;
        end
    end

    // R8
    status_read_clears_chk: assert property (@(posedge clk) disable iff (rst)
        (acc.st_rd && !set_pend) |=> !st.pend);

    // R7
    cp_blocks_rx_chk: assert property (@(posedge clk) disable iff (rst)
        (cra.cp_mode && !st.rx_ready) |=> !st.rx_ready);

    // R5
    tone_off_no_load_chk: assert property (@(posedge clk) disable iff (rst)
        !cra.tone_on |=> !tx_load);
endmodule

// File: rtl/tone_irq_out.sv
module tone_irq_out #(
    parameter int SYNC_STAGES = 2
) (
    input  logic clk,
    input  logic rst,
    input  logic irq_en,
    input  logic cp_mode,
    input  logic pend,
    input  logic cp_tone,
    output logic irq_cp_n
);
    logic [SYNC_STAGES-1:0] chain;

    for (genvar i = 0; i < SYNC_STAGES; i++) begin : g_sync
        if (i == 0) begin : g_first
            always_ff @(posedge clk) begin
                if (rst) chain[0] <= 1'b0;
                else     chain[0] <= cp_tone;
            end
        end else begin : g_next
            always_ff @(posedge clk) begin
                if (rst) chain[i] <= 1'b0;
                else     chain[i] <= chain[i-1];
            end
        end
    end

    always_ff @(posedge clk) begin
        if (rst)          irq_cp_n <= 1'b1;
        else if (!irq_en) irq_cp_n <= 1'b1;
        else if (cp_mode) irq_cp_n <= !chain[SYNC_STAGES-1];
        else              irq_cp_n <= !pend;
    end

    // R10
    irq_off_high_chk: assert property (@(posedge clk) disable iff (rst)
        !irq_en |=> irq_cp_n);
endmodule

// File: rtl/tone_host_regif.sv
module tone_host_regif
    import tone_regif_pkg::*;
#(
    parameter int SYNC_STAGES = 2
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          bus_style,
    input  logic          reg_sel,
    input  logic          rw_n,
    input  logic          bus_en,
    input  logic          rd_n,
    input  logic          wr_n,
    input  logic [DW-1:0] wdata,
    output logic [DW-1:0] rdata,
    input  logic          rx_valid,
    input  logic [DW-1:0] rx_code,
    input  logic          tx_done,
    input  logic          cp_tone,
    output logic [DW-1:0] tx_data,
    output logic          tx_load,
    output logic          tx_pwrdn,
    output logic          tone_on,
    output logic          cp_mode,
    output logic          irq_en,
    output logic          burst_en,
    output logic          test_en,
    output logic          single_tone,
    output logic          col_row,
    output logic          irq_cp_n
);
    access_t       acc;
    ctl_a_t        cra;
    ctl_b_t        crb;
    status_t       st;
    logic [DW-1:0] rx_data;

    tone_bus_decode u_dec (
        .clk, .rst, .bus_style, .reg_sel, .rw_n, .bus_en, .rd_n, .wr_n,
        .acc (acc)
    );

    tone_ctrl_regs u_ctl (
        .clk, .rst, .ctl_wr (acc.ctl_wr), .wdata, .cra (cra), .crb (crb)
    );

    tone_event_status u_evt (
        .clk, .rst, .acc (acc), .cra (cra), .crb (crb), .wdata,
        .rx_valid, .rx_code, .tx_done,
        .st (st), .rx_data (rx_data), .tx_data (tx_data), .tx_load (tx_load)
    );

    tone_irq_out #(.SYNC_STAGES(SYNC_STAGES)) u_irq (
        .clk, .rst, .irq_en (cra.irq_en), .cp_mode (cra.cp_mode),
        .pend (st.pend), .cp_tone, .irq_cp_n (irq_cp_n)
    );

    always_ff @(posedge clk) begin
        if (rst)            rdata <= '0;
        else if (acc.rx_rd) rdata <= rx_data;
        else if (acc.st_rd) rdata <= pack_status(st);
    end

    assign tone_on     = cra.tone_on;
    assign tx_pwrdn    = !cra.tone_on;
    assign cp_mode     = cra.cp_mode;
    assign irq_en      = cra.irq_en;
    assign burst_en    = crb.burst_en;
    assign test_en     = crb.test_en;
    assign single_tone = crb.single_tone;
    assign col_row     = crb.col_row;

    // R2
    rdata_hold_chk: assert property (@(posedge clk) disable iff (rst)
        (!acc.rx_rd && !acc.st_rd) |=> $stable(rdata));
endmodule

// File: tb/tb_tone_host_regif.sv
`timescale 1ns/1ps
module tb_tone_host_regif;
    logic clk = 1'b0;
    logic rst = 1'b1;
    logic bus_style = 1'b0, reg_sel = 1'b0, rw_n = 1'b1, bus_en = 1'b0;
    logic rd_n = 1'b1, wr_n = 1'b1;
    logic [3:0] wdata = '0, rdata, rx_code = '0, tx_data;
    logic rx_valid = 1'b0, tx_done = 1'b0, cp_tone = 1'b0;
    logic tx_load, tx_pwrdn, tone_on, cp_mode, irq_en;
    logic burst_en, test_en, single_tone, col_row, irq_cp_n;

    int total = 0, fails = 0;
    bit fire = 1'b0, finished = 1'b0;
    logic saw_load;
    logic [3:0] exp_q[$];
    string tag_q[$];

    always #2.5 clk = ~clk;

    tone_host_regif dut (.*);

    task automatic chk(input bit ok, input string tag, input int act, input int exp);
        total++;
        if (!ok) begin
            fails++;
            $display("FAIL %s: actual %0h expected %0h", tag, act, exp);
        end
    endtask

    // monitor: pops the scoreboard when a read completes
    initial forever begin
        @(posedge clk);
        #1;
        if (fire) begin
            logic [3:0] e;
            string t;
            e = exp_q.pop_front();
            t = tag_q.pop_front();
            chk(rdata === e, t, rdata, e);
        end
    end

    task automatic access(input bit style, input logic sel, input bit rd,
                          input logic [3:0] d, input int hold);
        @(negedge clk);
        bus_style = style; reg_sel = sel; wdata = d;
        if (style) begin rw_n = rd; bus_en = 1'b1; end
        else begin rd_n = !rd; wr_n = rd; end
        fire = rd;
        @(posedge clk);
        #1 saw_load = tx_load;
        #1 fire = 1'b0;
        for (int i = 1; i < hold; i++) @(negedge clk);
        @(negedge clk);
        bus_en = 1'b0; rd_n = 1'b1; wr_n = 1'b1;
    endtask

    task automatic rd(input bit style, input logic sel, input logic [3:0] e, input string tag);
        exp_q.push_back(e);
        tag_q.push_back(tag);
        access(style, sel, 1'b1, 4'h0, 1);
    endtask

    task automatic wr(input bit style, input logic sel, input logic [3:0] d);
        access(style, sel, 1'b0, d, 1);
    endtask

    task automatic pulse_rx(input logic [3:0] c);
        @(negedge clk); rx_valid = 1'b1; rx_code = c;
        @(negedge clk); rx_valid = 1'b0;
    endtask

    task automatic pulse_done();
        @(negedge clk); tx_done = 1'b1;
        @(negedge clk); tx_done = 1'b0;
    endtask

    task automatic idle(input int n);
        for (int i = 0; i < n; i++) @(negedge clk);
    endtask

    task automatic summary();
        $display("%0d/%0d checks passed", total - fails, total);
    endtask

    initial begin
        #(200000 * 5);
        if (!finished) begin
            total++; fails++;
            $display("FAIL watchdog: actual hung expected done");
            summary();
            $finish;
        end
    end

    initial begin
        idle(3);
        rst = 1'b0;
        idle(1);
        // R11 reset state
        chk(irq_cp_n === 1'b1, "R11 irq_cp_n", irq_cp_n, 1);
        chk(tx_pwrdn === 1'b1 && tone_on === 1'b0, "R11 tone", tone_on, 0);
        chk({col_row, single_tone, test_en, burst_en} === 4'h0, "R11 ctl B",
            {col_row, single_tone, test_en, burst_en}, 0);
        rd(1'b0, 1'b1, 4'b0100, "R11 R2 status after reset");

        // R3 R4 steering and field mapping
        wr(1'b0, 1'b1, 4'b1101);
        chk(tone_on === 1'b1 && irq_en === 1'b1 && tx_pwrdn === 1'b0, "R4 A bits",
            {irq_en, tone_on}, 3);
        wr(1'b1, 1'b1, 4'b1111);
        chk({col_row, single_tone, test_en, burst_en} === 4'hF, "R3 R4 write to B",
            {col_row, single_tone, test_en, burst_en}, 4'hF);
        chk(tone_on === 1'b1 && irq_en === 1'b1 && cp_mode === 1'b0, "R3 A kept",
            {irq_en, cp_mode, tone_on}, 5);
        wr(1'b1, 1'b1, 4'b0101);
        chk({col_row, single_tone, test_en, burst_en} === 4'hF, "R3 back to A",
            {col_row, single_tone, test_en, burst_en}, 4'hF);

        // R6 transmit write
        wr(1'b1, 1'b0, 4'h9);
        chk(saw_load === 1'b1, "R6 tx_load", saw_load, 1);
        chk(tx_data === 4'h9, "R6 tx_data", tx_data, 9);
        rd(1'b0, 1'b1, 4'b0000, "R6 tx empty cleared");

        // R8 burst tx_done interrupt
        pulse_done();
        idle(2);
        chk(irq_cp_n === 1'b0, "R8 irq low on tx_done", irq_cp_n, 0);
        rd(1'b1, 1'b1, 4'b0101, "R8 status pending");
        idle(2);
        chk(irq_cp_n === 1'b1, "R8 irq released", irq_cp_n, 1);

        // R7 R8 receive
        pulse_rx(4'hA);
        idle(2);
        chk(irq_cp_n === 1'b0, "R8 irq low on rx", irq_cp_n, 0);
        rd(1'b0, 1'b1, 4'b0111, "R7 status rx ready");
        rd(1'b1, 1'b0, 4'hA, "R7 R1 rx data");
        rd(1'b1, 1'b1, 4'b0100, "R7 rx ready cleared");

        // R10 interrupt disabled
        wr(1'b0, 1'b1, 4'b0001);
        pulse_rx(4'h3);
        idle(3);
        chk(irq_cp_n === 1'b1, "R10 irq stays high", irq_cp_n, 1);
        rd(1'b0, 1'b1, 4'b0110, "R10 no pending");
        rd(1'b0, 1'b0, 4'h3, "R7 rx data 3");

        // R5 tone off
        wr(1'b1, 1'b1, 4'b0000);
        chk(tx_pwrdn === 1'b1, "R5 powered down", tx_pwrdn, 1);
        wr(1'b1, 1'b0, 4'h5);
        chk(saw_load === 1'b0, "R5 no load", saw_load, 0);
        chk(tx_data === 4'h9, "R5 tx_data kept", tx_data, 9);
        rd(1'b1, 1'b1, 4'b0100, "R5 tx empty kept");

        // R7 R9 call-progress mode
        wr(1'b0, 1'b1, 4'b0110);
        chk(cp_mode === 1'b1, "R4 cp_mode", cp_mode, 1);
        pulse_rx(4'h7);
        rd(1'b0, 1'b1, 4'b0100, "R7 cp ignores rx");
        rd(1'b0, 1'b0, 4'h3, "R7 cp rx data kept");
        @(negedge clk); cp_tone = 1'b1;
        idle(5);
        chk(irq_cp_n === 1'b0, "R9 follows tone high", irq_cp_n, 0);
        @(negedge clk); cp_tone = 1'b0;
        idle(5);
        chk(irq_cp_n === 1'b1, "R9 follows tone low", irq_cp_n, 1);

        // R1 held strobe makes one access
        access(1'b1, 1'b1, 1'b0, 4'b1000, 4);
        wr(1'b0, 1'b1, 4'b0000);
        chk(col_row === 1'b0 && burst_en === 1'b0, "R1 held strobe once",
            {col_row, burst_en}, 0);
        chk(cp_mode === 1'b0, "R1 A after held write", cp_mode, 0);

        idle(2);
        chk(exp_q.size() == 0, "R2 scoreboard drained", exp_q.size(), 0);
        finished = 1'b1;
        summary();
        $finish;
    end
endmodule